// File: doc/BRIEF.md
# Character LCD Parallel Bus Sequencer

This block turns single-byte requests into strobed cycles on the parallel bus of a character LCD controller. A requester offers a register-select bit, a direction bit and a byte with a valid/ready handshake. The block then drives the select, direction and enable pins plus an 8-bit data bus with a separate output-enable for the tristate pad. Read results come back with a one-cycle response pulse. A mode input chooses full-byte transfers or nibble transfers. In nibble mode only the upper four bus lines carry data, and each byte takes two enable strobes, upper half first.

Before any write or data read, the block reads the controller status until the busy bit (bus line 7) reads clear. In nibble mode each status poll is two strobes: the busy bit and upper address bits come first, then the lower address bits. An initialisation sequencer can skip the poll with a bypass input, for the period when the busy bit cannot yet be trusted. A limit on consecutive busy readings keeps the poll from hanging. When the limit is reached the request is dropped and an error flag is raised. The setup time before the enable rises, the enable high time and the hold time after it falls are each a whole number of clock cycles, set by parameters.

Top module: `lcd_bus_engine`

## Requirements
- R1: During a requested transfer, `lcd_rs`/`lcd_rw` carry the request's select/direction bits. The encoding is 00 instruction write, 01 status read, 10 data write and 11 data read. Every poll strobe drives rs=0, rw=1.
- R2: With `nibble_mode`=0 a byte moves in one strobe over all eight data lines.
- R3: With `nibble_mode`=1 a byte moves in two strobes on `lcd_db_out[7:4]`, upper nibble first, with `lcd_db_out[3:0]` held at 0.
- R4: A write or data read starts only after the most recent status poll returned busy bit 0. The block repeats polls while the busy bit (bus line 7) reads 1.
- R5: In nibble mode one status poll takes two strobes, and the busy bit is taken from line 7 of the first one.
- R6: Read data is captured at the clock edge where `lcd_e` falls. It is returned on `rsp_byte` with a one-cycle `rsp_valid` pulse. In nibble mode the first nibble forms bits 7:4.
- R7: Select, direction and data are stable for at least SETUP_CYC cycles before `lcd_e` rises. `lcd_e` stays high for exactly EHIGH_CYC cycles, and the pins do not change while it is high.
- R8: `lcd_db_oe` is never 1 while `lcd_rw` is 1.
- R9: With `skip_poll`=1 at acceptance, the transfer is issued with no status strobe.
- R10: After POLL_LIMIT consecutive busy readings for one request, `poll_timeout` goes to 1 and the request is dropped with no transfer strobe. The flag returns to 0 when the next request is accepted.
- R11: A status-read request (rs=0, rw=1) is issued without a preceding poll. It returns the busy bit in bit 7 and the address counter in bits 6:0.
- R12: After reset `lcd_e`=0, `lcd_db_oe`=0, `req_ready`=1, `rsp_valid`=0 and `poll_timeout`=0.
- R13: `req_ready` is 0 from the cycle after acceptance until the request completes or is dropped, and `lcd_e` is never high while `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nibble_mode | input | 1 | 1 selects two-strobe nibble transfers |
| skip_poll | input | 1 | 1 skips the busy poll for the offered request |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_rs | input | 1 | Register select of the request |
| req_rw | input | 1 | Direction of the request, 1 = read |
| req_byte | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read result |
| rsp_byte | output | 8 | Read result |
| poll_timeout | output | 1 | Busy poll limit reached, request dropped |
| lcd_rs | output | 1 | Register select pin |
| lcd_rw | output | 1 | Direction pin |
| lcd_e | output | 1 | Enable strobe |
| lcd_db_out | output | 8 | Data bus drive value |
| lcd_db_oe | output | 1 | Data bus output enable |
| lcd_db_in | input | 8 | Data bus sampled value |

## Verification
The bench runs instruction writes, data writes, status reads and data reads in both bus widths. A responsive controller model scores every byte the block writes and every byte it returns.

- Preloading different busy counts tells apart a block that polls once, polls until clear, or skips the poll.
- Nibble-mode reads with unequal halves such as 0x3E show whether the nibbles are put together in the wrong order.
- A status read taken while the model is busy shows whether the busy bit lands on bit 7.
- A model that never clears exercises the poll limit. The request that follows shows the flag being cleared.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

  localparam int BUS_W = 8;
  localparam int NIB_W = BUS_W / 2;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_POLL,
    ENG_XFER
  } eng_state_t;

  typedef enum logic [1:0] {
    PH_OFF,
    PH_SETUP,
    PH_HIGH,
    PH_HOLD
  } strobe_ph_t;

  // Place one half of a byte on the upper bus lines, lower lines zero.
  function automatic logic [BUS_W-1:0] nib_on_upper(input logic [BUS_W-1:0] b,
                                                    input logic lower_half);
    logic [BUS_W-1:0] r;
    r = '0;
    r[BUS_W-1:NIB_W] = lower_half ? b[NIB_W-1:0] : b[BUS_W-1:NIB_W];
    return r;
  endfunction

endpackage

// File: rtl/lcd_strobe_seq.sv
module lcd_strobe_seq
  import lcd_bus_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int EHIGH_CYC = 3,
  parameter int HOLD_CYC  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic e_out,
  output logic sample,
  output logic done
);

  localparam int MAXC_A = (SETUP_CYC > EHIGH_CYC) ? SETUP_CYC : EHIGH_CYC;
  localparam int MAXC   = (MAXC_A > HOLD_CYC) ? MAXC_A : HOLD_CYC;
  localparam int CW     = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] EHIGH_LAST = CW'(EHIGH_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);

  strobe_ph_t    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          adv_en;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q + 1'b1;
    if (start) begin
      ph_d  = PH_SETUP;
      cnt_d = '0;
    end else begin
      case (ph_q)
        PH_SETUP: if (cnt_q == SETUP_LAST) begin ph_d = PH_HIGH; cnt_d = '0; end
        PH_HIGH:  if (cnt_q == EHIGH_LAST) begin ph_d = PH_HOLD; cnt_d = '0; end
        PH_HOLD:  if (cnt_q == HOLD_LAST)  begin ph_d = PH_OFF;  cnt_d = '0; end
        default:  cnt_d = '0;
      endcase
    end
  end

  assign adv_en = start || (ph_q != PH_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_OFF;
      cnt_q <= '0;
    end else if (adv_en) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign e_out  = (ph_q == PH_HIGH);
  assign sample = e_out && (cnt_q == EHIGH_LAST);
  assign done   = (ph_q == PH_HOLD) && (cnt_q == HOLD_LAST);

  // Checker: length of each enable pulse
  logic [CW:0] e_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     e_run_q <= '0;
    else if (e_out) e_run_q <= e_run_q + 1'b1;
    else            e_run_q <= '0;
  end

  // R7
  e_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(e_out) |-> (e_run_q == (CW+1)'(EHIGH_CYC)));

endmodule

// File: rtl/lcd_poll_guard.sv
module lcd_poll_guard #(
  parameter int POLL_LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic busy_seen,
  output logic at_last
);

  localparam int CW = $clog2(POLL_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(POLL_LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clear || busy_seen;

  always_comb begin
    if (clear) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign at_last = (cnt_q == LAST);

  // R10
  poll_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_seen && !clear && at_last) |=> (cnt_q == '0) || (cnt_q > LAST));

endmodule

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine
  import lcd_bus_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int EHIGH_CYC  = 3,
  parameter int HOLD_CYC   = 1,
  parameter int POLL_LIMIT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nibble_mode,
  input  logic             skip_poll,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_rs,
  input  logic             req_rw,
  input  logic [BUS_W-1:0] req_byte,
  output logic             rsp_valid,
  output logic [BUS_W-1:0] rsp_byte,
  output logic             poll_timeout,
  output logic             lcd_rs,
  output logic             lcd_rw,
  output logic             lcd_e,
  output logic [BUS_W-1:0] lcd_db_out,
  output logic             lcd_db_oe,
  input  logic [BUS_W-1:0] lcd_db_in
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  eng_state_t       state_q, state_d;
  logic             nib_q, nib_d;
  logic             bf_q, bf_d;
  logic [NIB_W-1:0] rdhi_q, rdhi_d;
  logic [BUS_W-1:0] rd_q, rd_d;
  logic             rspv_q, rspv_d;
  logic             tmo_q, tmo_d;
  logic             rq_rs_q, rq_rw_q, mode4_q;
  logic [BUS_W-1:0] rq_byte_q;
  logic             accept, start, gclear, busy_seen;
  logic             st_sample, st_done, guard_last;
  logic             in_xfer;

  lcd_strobe_seq #(
    .SETUP_CYC (SETUP_CYC),
    .EHIGH_CYC (EHIGH_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_strobe (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (start),
    .e_out  (lcd_e),
    .sample (st_sample),
    .done   (st_done)
  );

  lcd_poll_guard #(
    .POLL_LIMIT (POLL_LIMIT)
  ) u_guard (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clear     (gclear),
    .busy_seen (busy_seen),
    .at_last   (guard_last)
  );

  // Next state
  always_comb begin
    state_d   = state_q;
    nib_d     = nib_q;
    bf_d      = bf_q;
    rdhi_d    = rdhi_q;
    rd_d      = rd_q;
    rspv_d    = 1'b0;
    tmo_d     = tmo_q;
    accept    = 1'b0;
    start     = 1'b0;
    gclear    = 1'b0;
    busy_seen = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          start   = 1'b1;
          gclear  = 1'b1;
          nib_d   = 1'b0;
          tmo_d   = 1'b0;
          state_d = (skip_poll || (!req_rs && req_rw)) ? ENG_XFER : ENG_POLL;
        end
      end
      ENG_POLL: begin
        if (st_sample && !nib_q) bf_d = lcd_db_in[BUS_W-1];
        if (st_done) begin
          if (mode4_q && !nib_q) begin
            nib_d = 1'b1;
            start = 1'b1;
          end else begin
            nib_d = 1'b0;
            if (bf_q) begin
              busy_seen = 1'b1;
              if (guard_last) begin
                state_d = ENG_IDLE;
                tmo_d   = 1'b1;
              end else begin
                start = 1'b1;
              end
            end else begin
              state_d = ENG_XFER;
              start   = 1'b1;
            end
          end
        end
      end
      ENG_XFER: begin
        if (st_sample && rq_rw_q) begin
          if (!mode4_q)   rd_d   = lcd_db_in;
          else if (!nib_q) rdhi_d = lcd_db_in[BUS_W-1:NIB_W];
          else            rd_d   = {rdhi_q, lcd_db_in[BUS_W-1:NIB_W]};
        end
        if (st_done) begin
          if (mode4_q && !nib_q) begin
            nib_d = 1'b1;
            start = 1'b1;
          end else begin
            nib_d   = 1'b0;
            state_d = ENG_IDLE;
            rspv_d  = rq_rw_q;
          end
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ENG_IDLE;
      nib_q   <= 1'b0;
      bf_q    <= 1'b0;
      rdhi_q  <= '0;
      rd_q    <= '0;
      rspv_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      nib_q   <= nib_d;
      bf_q    <= bf_d;
      rdhi_q  <= rdhi_d;
      rd_q    <= rd_d;
      rspv_q  <= rspv_d;
      tmo_q   <= tmo_d;
    end
  end

  // Request capture, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rq_rs_q   <= 1'b0;
      rq_rw_q   <= 1'b1;
      rq_byte_q <= '0;
      mode4_q   <= 1'b0;
    end else if (accept) begin
      rq_rs_q   <= req_rs;
      rq_rw_q   <= req_rw;
      rq_byte_q <= req_byte;
      mode4_q   <= nibble_mode;
    end
  end

  // Pins
  assign in_xfer      = (state_q == ENG_XFER);
  assign lcd_rs       = in_xfer && rq_rs_q;
  assign lcd_rw       = !in_xfer || rq_rw_q;
  assign lcd_db_oe    = in_xfer && !rq_rw_q;
  assign lcd_db_out   = !lcd_db_oe ? '0 :
                        (mode4_q ? nib_on_upper(rq_byte_q, nib_q) : rq_byte_q);
  assign req_ready    = (state_q == ENG_IDLE);
  assign rsp_valid    = rspv_q;
  assign rsp_byte     = rd_q;
  assign poll_timeout = tmo_q;

  // R8
  bus_dir_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lcd_db_oe |-> !lcd_rw);

  // R7
  pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lcd_e && $past(lcd_e)) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_db_out)));

  // R13
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_ready |-> !lcd_e);

  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |=> !rsp_valid);

  // R10
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(poll_timeout) |-> (req_ready && !rsp_valid));

endmodule

// File: tb/sim_lcd_bus_engine.sv
module sim_lcd_bus_engine;

  localparam int CLK_PERIOD = 10;
  localparam int SETUP = 2;
  localparam int EHIGH = 3;
  localparam int HOLD  = 1;
  localparam int PLIM  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nibble_mode = 1'b0;
  logic       skip_poll = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_rs = 1'b0;
  logic       req_rw = 1'b0;
  logic [7:0] req_byte = 8'h00;
  logic       rsp_valid;
  logic [7:0] rsp_byte;
  logic       poll_timeout;
  logic       lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
  logic [7:0] lcd_db_out;
  logic [7:0] lcd_db_in = 8'h00;

  lcd_bus_engine #(
    .SETUP_CYC (SETUP),
    .EHIGH_CYC (EHIGH),
    .HOLD_CYC  (HOLD),
    .POLL_LIMIT(PLIM)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .nibble_mode(nibble_mode), .skip_poll(skip_poll),
    .req_valid(req_valid), .req_ready(req_ready), .req_rs(req_rs), .req_rw(req_rw),
    .req_byte(req_byte), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
    .poll_timeout(poll_timeout), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
    .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .lcd_db_in(lcd_db_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard queues
  logic [8:0] exp_wr[$];
  logic [7:0] exp_rd[$];

  // Controller model state
  bit         dev_mode4 = 1'b0;
  bit         allow_busy = 1'b0;
  int         busy_reload = 0;
  int         force_val = 0;
  int         force_seq = 0;
  int         seen_seq = 0;
  int         dev_busy = 0;
  logic [6:0] dev_ac = 7'h00;
  logic [7:0] dev_rdata = 8'h00;
  logic [7:0] rd_latch = 8'h00;
  logic [3:0] wr_hi = 4'h0;
  bit         nibph = 1'b0;
  bit         prev_e = 1'b0;
  int         e_cnt = 0;
  int         stable_cnt = 0;
  logic [10:0] prev_pins = '0;
  int         n_strobes = 0;
  int         n_status = 0;
  int         timing_bad = 0;
  int         oe_bad = 0;
  int         low_bad = 0;

  always @(negedge clk) begin
    logic [10:0] pins;
    logic [7:0]  full;
    logic [8:0]  e;
    if (force_seq != seen_seq) begin
      seen_seq = force_seq;
      dev_busy = force_val;
      nibph    = 1'b0;
    end
    pins = {lcd_rs, lcd_rw, lcd_db_oe, lcd_db_out};
    if (pins != prev_pins) stable_cnt = 0;
    else                   stable_cnt++;
    prev_pins = pins;
    if (lcd_db_oe && lcd_rw) oe_bad++;
    if (lcd_e) e_cnt++;
    if (lcd_e && !prev_e) begin
      if (stable_cnt < SETUP) timing_bad++;
      if (lcd_rw) begin
        if (!nibph) rd_latch = lcd_rs ? dev_rdata : {(dev_busy != 0), dev_ac};
        if (dev_mode4) lcd_db_in = nibph ? {rd_latch[3:0], 4'h0} : {rd_latch[7:4], 4'h0};
        else           lcd_db_in = rd_latch;
      end
    end
    if (!lcd_e && prev_e) begin
      n_strobes++;
      if (e_cnt != EHIGH) timing_bad++;
      if (stable_cnt < SETUP + EHIGH) timing_bad++;
      e_cnt = 0;
      if (dev_mode4 && !lcd_rw && lcd_db_out[3:0] != 4'h0) low_bad++;
      if (dev_mode4 && !nibph) begin
        wr_hi = lcd_db_out[7:4];
        nibph = 1'b1;
      end else begin
        nibph = 1'b0;
        full  = dev_mode4 ? {wr_hi, lcd_db_out[7:4]} : lcd_db_out;
        if (lcd_rw) begin
          if (!lcd_rs) begin
            n_status++;
            if (dev_busy > 0) dev_busy--;
          end
        end else begin
          chk(dev_busy == 0 || allow_busy, "R4 write strobed while busy", dev_busy, 0);
          if (exp_wr.size() == 0) begin
            chk(1'b0, "R1 unexpected write", {lcd_rs, full}, 0);
          end else begin
            e = exp_wr.pop_front();
            chk({lcd_rs, full} == e, "R1 R2 R3 write select and byte", {lcd_rs, full}, e);
          end
          if (lcd_rs) dev_ac = dev_ac + 7'd1;
          dev_busy = busy_reload;
        end
      end
    end
    prev_e = lcd_e;
  end

  // Monitor for read responses
  always @(negedge clk) begin
    logic [7:0] e;
    if (rsp_valid) begin
      if (exp_rd.size() == 0) begin
        chk(1'b0, "R6 unexpected response", rsp_byte, 0);
      end else begin
        e = exp_rd.pop_front();
        chk(rsp_byte == e, "R6 R11 read byte", rsp_byte, e);
      end
    end
  end

  task automatic set_busy(input int v);
    force_val = v;
    force_seq++;
    @(negedge clk);
  endtask

  task automatic issue(input bit rs, input bit rw, input logic [7:0] b, input bit skip);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_rs    = rs;
    req_rw    = rw;
    req_byte  = b;
    skip_poll = skip;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    skip_poll = 1'b0;
    chk(!req_ready, "R13 ready low after accept", req_ready, 0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_vec++;
    n_bad++;
    $display("FAIL R13 watchdog: actual=hung expected=idle");
    summary();
    $finish;
  end

  initial begin
    int s0, t0;
    repeat (3) @(negedge clk);
    chk(lcd_e == 1'b0 && lcd_db_oe == 1'b0, "R12 pins in reset", {lcd_e, lcd_db_oe}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R12 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0 && poll_timeout == 1'b0, "R12 flags after reset", {rsp_valid, poll_timeout}, 0);

    // 8-bit instruction write, controller idle: one poll, one strobe
    set_busy(0);
    busy_reload = 2;
    s0 = n_strobes; t0 = n_status;
    exp_wr.push_back({1'b0, 8'h38});
    issue(1'b0, 1'b0, 8'h38, 1'b0);
    chk(n_strobes - s0 == 2, "R2 strobes for 8-bit write", n_strobes - s0, 2);
    chk(n_status - t0 == 1, "R4 single poll when clear", n_status - t0, 1);

    // 8-bit data write, busy for two polls
    s0 = n_strobes; t0 = n_status;
    exp_wr.push_back({1'b1, 8'h41});
    issue(1'b1, 1'b0, 8'h41, 1'b0);
    chk(n_status - t0 == 3, "R4 polls until clear", n_status - t0, 3);

    // Status read while busy: no poll, BF on bit 7 and AC below
    s0 = n_strobes;
    exp_rd.push_back({1'b1, 7'd1});
    issue(1'b0, 1'b1, 8'h00, 1'b0);
    chk(n_strobes - s0 == 1, "R11 status read without poll", n_strobes - s0, 1);

    // 8-bit data read with one busy reading left
    dev_rdata = 8'hA5;
    t0 = n_status;
    exp_rd.push_back(8'hA5);
    issue(1'b1, 1'b1, 8'h00, 1'b0);
    chk(n_status - t0 == 2, "R4 poll before data read", n_status - t0, 2);

    // Nibble mode data write, one busy reading
    nibble_mode = 1'b1;
    dev_mode4   = 1'b1;
    busy_reload = 1;
    set_busy(1);
    s0 = n_strobes; t0 = n_status;
    exp_wr.push_back({1'b1, 8'h5C});
    issue(1'b1, 1'b0, 8'h5C, 1'b0);
    chk(n_strobes - s0 == 6, "R3 R5 strobes for nibble write", n_strobes - s0, 6);
    chk(n_status - t0 == 2, "R5 nibble polls until clear", n_status - t0, 2);

    // Nibble mode data read with distinct halves
    dev_rdata = 8'h3E;
    s0 = n_strobes;
    exp_rd.push_back(8'h3E);
    issue(1'b1, 1'b1, 8'h00, 1'b0);
    chk(n_strobes - s0 == 6, "R5 strobes for nibble read", n_strobes - s0, 6);

    // Nibble mode status read while busy
    set_busy(1);
    s0 = n_strobes;
    exp_rd.push_back({1'b1, 7'd2});
    issue(1'b0, 1'b1, 8'h00, 1'b0);
    chk(n_strobes - s0 == 2, "R11 nibble status read strobes", n_strobes - s0, 2);

    // Poll bypass while the model reports busy
    nibble_mode = 1'b0;
    dev_mode4   = 1'b0;
    busy_reload = 0;
    set_busy(3);
    allow_busy = 1'b1;
    s0 = n_strobes; t0 = n_status;
    exp_wr.push_back({1'b0, 8'h01});
    issue(1'b0, 1'b0, 8'h01, 1'b1);
    allow_busy = 1'b0;
    chk(n_status - t0 == 0, "R9 no poll with bypass", n_status - t0, 0);
    chk(n_strobes - s0 == 1, "R9 single strobe with bypass", n_strobes - s0, 1);

    // Controller never clears: poll limit, request dropped
    set_busy(1000);
    t0 = n_status;
    issue(1'b1, 1'b0, 8'h77, 1'b0);
    chk(poll_timeout == 1'b1, "R10 timeout flag raised", poll_timeout, 1);
    chk(n_status - t0 == PLIM, "R10 busy readings before drop", n_status - t0, PLIM);
    chk(dev_ac == 7'd2, "R10 no data written on drop", dev_ac, 2);

    // Next request clears the flag
    set_busy(0);
    exp_wr.push_back({1'b1, 8'h12});
    issue(1'b1, 1'b0, 8'h12, 1'b0);
    chk(poll_timeout == 1'b0, "R10 flag cleared by next request", poll_timeout, 0);

    repeat (4) @(negedge clk);
    chk(timing_bad == 0, "R7 setup and enable width", timing_bad, 0);
    chk(oe_bad == 0, "R8 bus driven during read", oe_bad, 0);
    chk(low_bad == 0, "R3 lower lines zero in nibble mode", low_bad, 0);
    chk(exp_wr.size() == 0, "R1 writes not seen", exp_wr.size(), 0);
    chk(exp_rd.size() == 0, "R6 responses not seen", exp_rd.size(), 0);

    summary();
    $finish;
  end

endmodule